// File: doc/BRIEF.md
# Stepped Frequency Sweep Sequencer

This block steps an excitation source through a programmed series of frequencies. It has no knowledge of the oscillator itself. Software loads four settings: a base frequency word, a step word, the index of the last point, and a settling setting. It then drives the sweep by writing command codes into the top nibble of a 16-bit control word. The block presents the current 24-bit frequency word to a phase accumulator. It also presents a 9-bit point index.

At every point the block waits for the oscillator to report a programmed number of completed output periods. It then raises a one-cycle request to a downstream measurement engine. It holds in a waiting state until that engine reports completion. While the block is held at the base frequency it never asks for a measurement. This lets an external load settle for as long as software chooses. Two fields of the control word, the output range and the gain choice, pass straight through to analog settings outside the block.

Top module: `sweep_sequencer`

## Requirements
- R1: After synchronous reset the block is powered down (`pwr_down`=1, `standby`=0). `freq_word`, `freq_index`, `meas_req`, `data_valid`, `sweep_done`, `out_range` and `gain_unity` are all zero. This matches a stored control value of 0xA000.
- R2: The command is bits [15:12] of a control write, and it acts once per write. The codes are 0000 no-op, 0001 hold at base, 0010 begin sweep, 0011 next point, 0100 re-measure, 1010 power down and 1011 standby. Every other code leaves all outputs unchanged.
- R3: Code 0001 loads the base word into `freq_word` and clears `freq_index`. The block then holds there with no `meas_req`, however many output-period ticks arrive.
- R4: Code 0010 from the hold state starts a settle count of `cyc_tick` pulses. `meas_req` pulses in the cycle after the tick that completes the target. A target of zero requests in the cycle after the write.
- R5: The settle word has a period count in bits [8:0] and a multiplier code in bits [10:9]. The target is the count times 1 for code 00, times 2 for 01 and times 4 for 11. The reserved code 10 acts as times 1.
- R6: Code 0011 after a completed measurement adds the step word to `freq_word`, modulo 2^24. It adds one to `freq_index` and restarts the settle count.
- R7: Code 0100 after a completed measurement leaves `freq_word` and `freq_index` unchanged and restarts the settle count. This yields a fresh `meas_req`.
- R8: `data_valid` sets when `meas_done` arrives while a request is outstanding. It clears on the next accepted step or re-measure command.
- R9: `sweep_done` sets when a measurement completes at an index equal to the programmed last index. After that, step commands leave `freq_word` and `freq_index` unchanged.
- R10: A control write with bit 4 set does the following regardless of its command field. It restores `freq_word` to the base word, clears `freq_index`, `data_valid` and `sweep_done`, and returns to idle. In idle a begin-sweep code and ticks produce no `meas_req`.
- R11: Code 1010 sets `pwr_down` and clears `standby`. Code 1011 does the reverse. Every control write copies bits [9:8] to `out_range` and bit 7 to `gain_unity`.
- R12: `meas_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: command [15:12], range [9:8], gain [7], clear [4] |
| start_we | input | 1 | Base frequency write strobe |
| start_wdata | input | 24 | Base frequency word |
| step_we | input | 1 | Step word write strobe |
| step_wdata | input | 24 | Frequency step word |
| count_we | input | 1 | Last-index write strobe |
| count_wdata | input | 9 | Index of the final sweep point |
| settle_we | input | 1 | Settle setting write strobe |
| settle_wdata | input | 11 | Multiplier code [10:9], period count [8:0] |
| cyc_tick | input | 1 | One pulse per completed output period |
| meas_done | input | 1 | Measurement engine finished |
| freq_word | output | 24 | Current frequency word for the phase accumulator |
| freq_index | output | 9 | Current point index |
| meas_req | output | 1 | One-cycle measurement request |
| data_valid | output | 1 | Result of current point available |
| sweep_done | output | 1 | Final point measured |
| pwr_down | output | 1 | Power-down mode flag |
| standby | output | 1 | Standby mode flag |
| out_range | output | 2 | Excitation range field, passed through |
| gain_unity | output | 1 | Gain choice bit, passed through |

## Verification
The hardest state to reach is the end of a sweep. The bench has to walk every point in turn, each with a full settle count of ticks and a measurement handshake. Only then can it show that a further step command is refused. The bench reaches it with a directed sweep over a short programmed length, and it inserts a re-measure in the middle. The settle target is a product of a count and a coded multiplier, so randomized settle settings are replayed from hold. For each one the bench checks that the request is absent one tick short of the target and present right after it. These settings include the reserved code and a zero count.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'b0000,
    OP_INIT  = 4'b0001,
    OP_START = 4'b0010,
    OP_INC   = 4'b0011,
    OP_REP   = 4'b0100,
    OP_PDOWN = 4'b1010,
    OP_STBY  = 4'b1011
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_MEAS,
    ST_WAIT
  } st_e;

  typedef struct packed {
    logic init;
    logic start;
    logic inc;
    logic rep;
    logic pdown;
    logic stby;
    logic clr;
  } cmd_s;
endpackage

// File: rtl/sweep_cmd_decode.sv
module sweep_cmd_decode
  import sweep_pkg::*;
(
  input  logic            we,
  input  logic [OP_W-1:0] op,
  input  logic            clr_bit,
  output cmd_s            cmd
);
  always_comb begin
    cmd = '0;
    if (we) begin
      if (clr_bit) begin
        cmd.clr = 1'b1;
      end else begin
        case (op)
          OP_INIT:  cmd.init  = 1'b1;
          OP_START: cmd.start = 1'b1;
          OP_INC:   cmd.inc   = 1'b1;
          OP_REP:   cmd.rep   = 1'b1;
          OP_PDOWN: cmd.pdown = 1'b1;
          OP_STBY:  cmd.stby  = 1'b1;
          default:  cmd = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sweep_settle_timer.sv
module sweep_settle_timer #(
  parameter int CNT_W = 9,
  parameter int MUL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [MUL_W-1:0] cfg_mul,
  output logic             expired
);
  localparam int TGT_W = CNT_W + 2;

  logic [TGT_W-1:0] target_q;
  logic [TGT_W-1:0] count_q;
  logic [1:0]       shift;

  always_comb begin
    case (cfg_mul)
      2'b01:   shift = 2'd1;
      2'b11:   shift = 2'd2;
      default: shift = 2'd0;
    endcase
  end

  assign expired = (count_q == target_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      count_q  <= '0;
    end else if (load) begin
      target_q <= {2'b00, cfg_cnt} << shift;
      count_q  <= '0;
    end else if (run && tick && !expired) begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/sweep_freq_stepper.sv
module sweep_freq_stepper #(
  parameter int FW = 24,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_base,
  input  logic          step_en,
  input  logic [FW-1:0] base_word,
  input  logic [FW-1:0] step_word,
  output logic [FW-1:0] freq,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freq <= '0;
      idx  <= '0;
    end else if (load_base) begin
      freq <= base_word;
      idx  <= '0;
    end else if (step_en) begin
      freq <= freq + step_word;
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
  import sweep_pkg::*;
#(
  parameter int          FW       = 24,
  parameter int          IW       = 9,
  parameter int          SCNT_W   = 9,
  parameter int          CTRL_W   = 16,
  parameter logic [15:0] CTRL_RST = 16'hA000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                start_we,
  input  logic [FW-1:0]       start_wdata,
  input  logic                step_we,
  input  logic [FW-1:0]       step_wdata,
  input  logic                count_we,
  input  logic [IW-1:0]       count_wdata,
  input  logic                settle_we,
  input  logic [SCNT_W+1:0]   settle_wdata,
  input  logic                cyc_tick,
  input  logic                meas_done,
  output logic [FW-1:0]       freq_word,
  output logic [IW-1:0]       freq_index,
  output logic                meas_req,
  output logic                data_valid,
  output logic                sweep_done,
  output logic                pwr_down,
  output logic                standby,
  output logic [1:0]          out_range,
  output logic                gain_unity
);
  localparam int OP_LSB   = CTRL_W - OP_W;
  localparam int CLR_BIT  = 4;
  localparam int GAIN_BIT = 7;
  localparam int RNG_LSB  = 8;
  localparam int MUL_LSB  = SCNT_W;

  logic [FW-1:0]     base_q, step_q;
  logic [IW-1:0]     last_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [1:0]        smul_q;
  st_e               st_q;
  cmd_s              cmd;
  logic              expired, load_base, step_en, timer_load, meas_fin;
  logic              unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata[OP_LSB-1:RNG_LSB+2], ctrl_wdata[GAIN_BIT-1:CLR_BIT+1],
                              ctrl_wdata[CLR_BIT-1:0]};

  sweep_cmd_decode u_dec (
    .we      (ctrl_we),
    .op      (ctrl_wdata[OP_LSB +: OP_W]),
    .clr_bit (ctrl_wdata[CLR_BIT]),
    .cmd     (cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
      last_q <= '0;
      scnt_q <= '0;
      smul_q <= '0;
    end else begin
      if (start_we)  base_q <= start_wdata;
      if (step_we)   step_q <= step_wdata;
      if (count_we)  last_q <= count_wdata;
      if (settle_we) begin
        scnt_q <= settle_wdata[SCNT_W-1:0];
        smul_q <= settle_wdata[MUL_LSB +: 2];
      end
    end
  end

  assign load_base  = cmd.init | cmd.clr;
  assign step_en    = cmd.inc && (st_q == ST_WAIT) && !sweep_done && (freq_index < last_q);
  assign timer_load = (cmd.start && st_q == ST_HOLD) || step_en || (cmd.rep && st_q == ST_WAIT);
  assign meas_fin   = (st_q == ST_MEAS) && meas_done;

  sweep_freq_stepper #(.FW(FW), .IW(IW)) u_step (
    .clk       (clk),
    .rst       (rst),
    .load_base (load_base),
    .step_en   (step_en),
    .base_word (base_q),
    .step_word (step_q),
    .freq      (freq_word),
    .idx       (freq_index)
  );

  sweep_settle_timer #(.CNT_W(SCNT_W), .MUL_W(2)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .run     (st_q == ST_SETTLE),
    .tick    (cyc_tick),
    .cfg_cnt (scnt_q),
    .cfg_mul (smul_q),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      meas_req   <= 1'b0;
      data_valid <= 1'b0;
      sweep_done <= 1'b0;
      pwr_down   <= 1'b1;
      standby    <= 1'b0;
      out_range  <= CTRL_RST[RNG_LSB +: 2];
      gain_unity <= CTRL_RST[GAIN_BIT];
    end else begin
      meas_req <= 1'b0;
      if (ctrl_we) begin
        out_range  <= ctrl_wdata[RNG_LSB +: 2];
        gain_unity <= ctrl_wdata[GAIN_BIT];
      end
      if (cmd.clr || cmd.pdown || cmd.stby) begin
        st_q       <= ST_IDLE;
        data_valid <= 1'b0;
        sweep_done <= 1'b0;
        if (cmd.pdown) begin
          pwr_down <= 1'b1;
          standby  <= 1'b0;
        end
        if (cmd.stby) begin
          pwr_down <= 1'b0;
          standby  <= 1'b1;
        end
      end else if (cmd.init) begin
        st_q       <= ST_HOLD;
        data_valid <= 1'b0;
        sweep_done <= 1'b0;
        pwr_down   <= 1'b0;
        standby    <= 1'b0;
      end else if (timer_load) begin
        st_q       <= ST_SETTLE;
        data_valid <= 1'b0;
        sweep_done <= 1'b0;
      end else if (st_q == ST_SETTLE && expired) begin
        st_q     <= ST_MEAS;
        meas_req <= 1'b1;
      end else if (meas_fin) begin
        st_q       <= ST_WAIT;
        data_valid <= 1'b1;
        sweep_done <= (freq_index == last_q);
      end
    end
  end
endmodule

// File: rtl/sweep_sequencer_chk.sv
module sweep_sequencer_chk #(
  parameter int FW = 24,
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_we,
  input logic [15:0]   ctrl_wdata,
  input logic          meas_req,
  input logic [FW-1:0] freq_word,
  input logic [IW-1:0] freq_index,
  input logic          data_valid,
  input logic          sweep_done,
  input logic          pwr_down
);
  logic [3:0] op;
  logic       clr;
  assign op  = ctrl_wdata[15:12];
  assign clr = ctrl_wdata[4];

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    meas_req |=> !meas_req); // R12

  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (sweep_done && !ctrl_we) |=> $stable(freq_index)); // R9

  AST_REPEAT_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !clr && op == 4'b0100 && data_valid) |=> !data_valid); // R8

  AST_REPEAT_KEEPS_FREQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !clr && op == 4'b0100) |=> $stable(freq_word)); // R7

  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && clr) |=> (freq_index == '0 && !data_valid && !sweep_done)); // R10

  AST_INIT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !clr && op == 4'b0001) |=> (freq_index == '0 && !meas_req)); // R3

  AST_POWER_DOWN: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !clr && op == 4'b1010) |=> pwr_down); // R11
endmodule

bind sweep_sequencer sweep_sequencer_chk #(.FW(FW), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .meas_req   (meas_req),
  .freq_word  (freq_word),
  .freq_index (freq_index),
  .data_valid (data_valid),
  .sweep_done (sweep_done),
  .pwr_down   (pwr_down)
);

// File: tb/sim_sweep_sequencer.sv
`timescale 1ns/1ps
module sim_sweep_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic        start_we = 1'b0, step_we = 1'b0, count_we = 1'b0, settle_we = 1'b0;
  logic [23:0] start_wdata = '0, step_wdata = '0;
  logic [8:0]  count_wdata = '0;
  logic [10:0] settle_wdata = '0;
  logic        cyc_tick = 1'b0, meas_done = 1'b0;
  logic [23:0] freq_word;
  logic [8:0]  freq_index;
  logic        meas_req, data_valid, sweep_done, pwr_down, standby, gain_unity;
  logic [1:0]  out_range;

  int checks = 0, failures = 0;
  int req_cnt = 0, req_ticks = 0, tick_ctr = 0, wide_req = 0;
  logic prev_req = 1'b0;
  logic [23:0] base, step;

  always #4 clk = ~clk;

  sweep_sequencer u0 (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .start_we(start_we), .start_wdata(start_wdata), .step_we(step_we), .step_wdata(step_wdata),
    .count_we(count_we), .count_wdata(count_wdata), .settle_we(settle_we), .settle_wdata(settle_wdata),
    .cyc_tick(cyc_tick), .meas_done(meas_done), .freq_word(freq_word), .freq_index(freq_index),
    .meas_req(meas_req), .data_valid(data_valid), .sweep_done(sweep_done), .pwr_down(pwr_down),
    .standby(standby), .out_range(out_range), .gain_unity(gain_unity)
  );

  always @(negedge clk) begin
    if (meas_req) begin
      req_cnt++;
      req_ticks = tick_ctr;
      if (prev_req) wide_req++;
    end
    prev_req = meas_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int settle_target(input int n, input int m);
    case (m)
      1: return n * 2;
      3: return n * 4;
      default: return n;
    endcase
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [3:0] op, input logic [11:0] low);
    @(posedge clk); #1;
    ctrl_we = 1'b1; ctrl_wdata = {op, low};
    @(posedge clk); #1;
    ctrl_we = 1'b0; tick_ctr = 0;
  endtask

  task automatic wr_cfg(input logic [23:0] b, input logic [23:0] s, input logic [8:0] last,
                        input logic [10:0] st);
    @(posedge clk); #1;
    start_we = 1'b1; step_we = 1'b1; count_we = 1'b1; settle_we = 1'b1;
    start_wdata = b; step_wdata = s; count_wdata = last; settle_wdata = st;
    @(posedge clk); #1;
    start_we = 1'b0; step_we = 1'b0; count_we = 1'b0; settle_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; cyc_tick = 1'b1;
      @(posedge clk); #1; cyc_tick = 1'b0; tick_ctr++;
      cyc(2);
    end
  endtask

  task automatic pulse_done();
    @(posedge clk); #1; meas_done = 1'b1;
    @(posedge clk); #1; meas_done = 1'b0;
  endtask

  task automatic measure(input int tgt, input string tag);
    int r0;
    r0 = req_cnt;
    ticks(tgt);
    cyc(3);
    chk(req_cnt == r0 + 1, tag, req_cnt, r0 + 1);
    chk(req_ticks == tgt, tag, req_ticks, tgt);
    pulse_done();
    chk(data_valid == 1'b1, "R8 valid after done", data_valid, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd7301));
    cyc(4); rst = 1'b0; cyc(1);
    // R1: reset state
    chk(pwr_down == 1 && standby == 0, "R1 mode", {pwr_down, standby}, 2);
    chk(freq_word == 0 && freq_index == 0, "R1 freq", freq_word, 0);
    chk(!meas_req && !data_valid && !sweep_done && out_range == 0 && !gain_unity, "R1 flags", 1, 0);

    // R2: unlisted code and no-op change nothing
    wr_ctrl(4'b0101, 12'h000);
    chk(pwr_down == 1 && standby == 0 && freq_word == 0, "R2 unlisted code", {pwr_down, standby}, 2);
    wr_ctrl(4'b0000, 12'h000);
    chk(pwr_down == 1 && standby == 0, "R2 nop", {pwr_down, standby}, 2);

    // R11: standby with pass-through fields (range [9:8]=11, gain [7]=1)
    wr_ctrl(4'b1011, 12'h380);
    chk(standby == 1 && pwr_down == 0, "R11 standby", {pwr_down, standby}, 1);
    chk(out_range == 2'b11 && gain_unity == 1, "R11 fields", {out_range, gain_unity}, 7);

    // R3: hold at base, no request under ticks
    base = 24'($urandom()); step = 24'($urandom());
    wr_cfg(base, step, 9'd3, {2'b00, 9'd2});
    wr_ctrl(4'b0001, 12'h000);
    chk(freq_word == base && freq_index == 0, "R3 base loaded", freq_word, base);
    r0 = req_cnt;
    ticks(6);
    chk(req_cnt == r0, "R3 no request in hold", req_cnt, r0);

    // R4/R5: randomized settle targets incl. zero count and reserved code
    for (int k = 0; k < 7; k++) begin
      int n, m, t;
      n = (k == 0) ? 0 : $urandom_range(1, 5);
      m = (k == 1) ? 2 : $urandom_range(0, 3);
      t = settle_target(n, m);
      wr_cfg(base, step, 9'd3, {2'(m), 9'(n)});
      wr_ctrl(4'b0001, 12'h000);
      wr_ctrl(4'b0010, 12'h000);
      r0 = req_cnt;
      if (t > 0) begin
        ticks(t - 1);
        chk(req_cnt == r0, "R4 early request", req_cnt, r0);
        ticks(1);
      end
      cyc(3);
      chk(req_cnt == r0 + 1 && req_ticks == t, "R5 settle target", req_ticks, t);
    end

    // R6-R9: directed sweep over indices 0..3, target 2 x2 = 4
    wr_cfg(base, step, 9'd3, {2'b01, 9'd2});
    wr_ctrl(4'b0001, 12'h000);
    wr_ctrl(4'b0010, 12'h000);
    measure(4, "R4 first point");
    for (int k = 1; k <= 3; k++) begin
      wr_ctrl(4'b0011, 12'h000);
      chk(freq_index == 9'(k), "R6 index", freq_index, k);
      chk(freq_word == 24'(base + step * k), "R6 freq", freq_word, 24'(base + step * k));
      chk(data_valid == 0, "R8 valid cleared by step", data_valid, 0);
      measure(4, "R6 point request");
      if (k == 2) begin
        chk(sweep_done == 0, "R9 not yet done", sweep_done, 0);
        wr_ctrl(4'b0100, 12'h000);
        chk(freq_word == 24'(base + step * 2) && freq_index == 2, "R7 repeat keeps freq", freq_word,
            24'(base + step * 2));
        chk(data_valid == 0, "R8 valid cleared by repeat", data_valid, 0);
        measure(4, "R7 repeat request");
      end
    end
    chk(sweep_done == 1, "R9 done at last index", sweep_done, 1);
    wr_ctrl(4'b0011, 12'h000);
    chk(freq_index == 3 && freq_word == 24'(base + step * 3), "R9 step ignored", freq_index, 3);

    // R6: 24-bit wrap
    wr_cfg(24'hFFFF00, 24'h000200, 9'd2, {2'b00, 9'd1});
    wr_ctrl(4'b0001, 12'h000);
    wr_ctrl(4'b0010, 12'h000);
    measure(1, "R6 wrap first");
    wr_ctrl(4'b0011, 12'h000);
    chk(freq_word == 24'h000100, "R6 wrap", freq_word, 24'h000100);

    // R10: clear bit [4] mid-settle, then start and ticks do nothing
    wr_ctrl(4'b0011, 12'h010);
    chk(freq_word == 24'hFFFF00 && freq_index == 0, "R10 freq restored", freq_word, 24'hFFFF00);
    chk(!data_valid && !sweep_done, "R10 flags cleared", {data_valid, sweep_done}, 0);
    wr_ctrl(4'b0010, 12'h000);
    r0 = req_cnt;
    ticks(5);
    chk(req_cnt == r0, "R10 no request from idle", req_cnt, r0);

    // R11: power down
    wr_ctrl(4'b1010, 12'h000);
    chk(pwr_down == 1 && standby == 0, "R11 power down", {pwr_down, standby}, 2);

    // R12: request width
    chk(wide_req == 0, "R12 single-cycle request", wide_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule